// File: doc/BRIEF.md
# Card Configuration and Status Register Block

This block holds the two configuration registers that a host programs through attribute memory on a removable storage card: a configuration index register and a configuration-and-status register. The host reaches them with byte-wide reads and writes, one register per even attribute address. From their contents, and from a few status flags supplied by the rest of the card, the block produces an active-low status-change pin, a ready/busy pin, a power-down request, and an I/O address decode that yields a hit flag and a 3-bit task-file register offset.

The host request port is a valid/ready stream that never applies back-pressure: `req_ready` is held high, so every cycle with `req_valid` high is accepted. A read produces exactly one `rsp_valid` pulse on the following cycle, with the register contents as they stood in the request cycle. The response channel has no ready input, so the host must take the data in the cycle it is presented. Writes produce no response.

The low two bits of the configuration index choose how the card's task file is reached: memory mapped, I/O at a host-programmed 16-byte-aligned base, or one of two fixed I/O address maps. The storage controller, the task file itself and the real power sequencing sit outside this block.

Top module: `card_cfg_ctrl`

## Requirements
- R1: After reset both registers read 0x00, `rdy_bsy` is 1 (ready), `stschg_n` is 1, `pwr_down_req` is 0 and `io_hit` is 0.
- R2: Address 0x200 holds a 6-bit configuration index in bits 5:0; bits 7:6 read 0; index bits 1:0 select the map (0 memory, 1 programmable I/O base, 2 primary fixed I/O map, 3 secondary fixed I/O map).
- R3: Address 0x202 reads {Changed, SigChg, IOis8, 0, 0, PwrDwn, Int, 0} from bit 7 down to bit 0; only bits 6, 5 and 2 are stored by a write, and written values of bits 7, 4, 3, 1 and 0 are discarded.
- R4: Changed (bit 7 of 0x202) reads 1 whenever `rdy_chg` or `wp_chg` is 1, and 0 otherwise.
- R5: `stschg_n` is 0 exactly when Changed is 1, SigChg is 1 and an I/O map (index bits 1:0 nonzero) is selected; in memory-mapped mode it is 1 whatever Changed and SigChg hold.
- R6: IOis8 reads back as written but changes no output: `rdy_bsy`, `stschg_n`, `pwr_down_req` and the I/O decode are unaffected by it.
- R7: A write to 0x202 whose bit 2 differs from the stored PwrDwn drives `rdy_bsy` to 0 from the next cycle; a write that leaves PwrDwn unchanged leaves `rdy_bsy` at 1.
- R8: Once busy, `rdy_bsy` stays 0 until a cycle with `pwr_ack` 1 and `pwr_ack_down` equal to the stored PwrDwn; it returns to 1 in the cycle after that acknowledge, and an acknowledge for the other state is ignored.
- R9: Int (bit 1 of 0x202) reads 1 exactly when `irq_pending` and `irq_enable` are both 1, in every map mode.
- R10: In map 1, `io_hit` is 1 when `io_addr[15:4]` equals `io_base` and offset bits 3:0 are 0x0–0x7 (register offset = bits 2:0) or 0xE–0xF (register offset 6 or 7); on any miss `io_ofs` is 0.
- R11: In map 2, addresses 0x1F0–0x1F7 hit with offset 0–7 and 0x3F6–0x3F7 hit with offset 6–7; other addresses miss.
- R12: In map 3, addresses 0x170–0x177 hit with offset 0–7 and 0x376–0x377 hit with offset 6–7; in map 0 `io_hit` is always 0.
- R13: `req_ready` is always 1; a read gives `rsp_valid` in the next cycle only; reads of any address other than 0x200 and 0x202 return 0x00, and writes to such addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host attribute access request |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Attribute byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_data | output | 8 | Read data |
| rdy_chg | input | 1 | Ready-change flag from pin-replacement logic |
| wp_chg | input | 1 | Write-protect-change flag from pin-replacement logic |
| irq_pending | input | 1 | Internal interrupt request |
| irq_enable | input | 1 | Interrupt enable from device control |
| pwr_ack | input | 1 | Requested power state reached |
| pwr_ack_down | input | 1 | State being acknowledged (1 = powered down) |
| io_addr | input | 16 | Host I/O address to decode |
| io_base | input | 12 | Base address bits 15:4 for map 1 |
| stschg_n | output | 1 | Active-low status-change pin |
| rdy_bsy | output | 1 | 1 = ready, 0 = busy |
| pwr_down_req | output | 1 | Stored power-down request |
| io_hit | output | 1 | Decoded address falls in the task-file window |
| io_ofs | output | 3 | Task-file register offset |

## Verification
The hardest state to reach is a busy period that must survive an acknowledge for the wrong power state and then end only on the matching one, while Changed, SigChg and the map mode interact on the status-change pin. The bench programs PwrDwn through the register port, pulses `pwr_ack` with the opposite state first and checks `rdy_bsy` holds low, then acknowledges the right state; it repeats the toggle in the other direction and writes the same PwrDwn value again to show no busy period starts. The status pin is walked through each combination of change flag, SigChg and memory versus I/O map.

// File: rtl/card_cfg_pkg.sv
package card_cfg_pkg;

  typedef enum logic [1:0] {
    MAP_MEM    = 2'd0,
    MAP_IO_ANY = 2'd1,
    MAP_IO_PRI = 2'd2,
    MAP_IO_SEC = 2'd3
  } map_mode_e;

  // Fixed I/O windows: 8-byte task file plus 2-byte alternate pair.
  localparam logic [15:0] PRI_MAIN_BASE = 16'h01F0;
  localparam logic [15:0] PRI_ALT_BASE  = 16'h03F6;
  localparam logic [15:0] SEC_MAIN_BASE = 16'h0170;
  localparam logic [15:0] SEC_ALT_BASE  = 16'h0376;

  // Status register bit positions.
  localparam int unsigned ST_CHANGED = 7;
  localparam int unsigned ST_SIGCHG  = 6;
  localparam int unsigned ST_IOIS8   = 5;
  localparam int unsigned ST_PWRDWN  = 2;
  localparam int unsigned ST_INT     = 1;

endpackage

// File: rtl/card_cfg_regs.sv
module card_cfg_regs
  import card_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned IDX_W    = 6,
  parameter logic [9:0]  IDX_ADDR = 10'h200,
  parameter logic [9:0]  ST_ADDR  = 10'h202
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  input  logic              changed,
  input  logic              int_req,
  output logic              rsp_valid,
  output logic [7:0]        rsp_data,
  output logic [IDX_W-1:0]  cfg_index,
  output logic              sigchg,
  output logic              iois8,
  output logic              pwrdwn,
  output logic              st_wr,
  output logic              st_wr_pd
);

  logic idx_sel, st_sel;
  logic [7:0] rd_mux;

  assign idx_sel  = (req_addr == ADDR_W'(IDX_ADDR));
  assign st_sel   = (req_addr == ADDR_W'(ST_ADDR));
  assign st_wr    = req_valid && req_write && st_sel;
  assign st_wr_pd = req_wdata[ST_PWRDWN];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_index <= '0;
      sigchg    <= 1'b0;
      iois8     <= 1'b0;
      pwrdwn    <= 1'b0;
    end else if (req_valid && req_write) begin
      if (idx_sel) cfg_index <= req_wdata[IDX_W-1:0];
      if (st_sel) begin
        sigchg <= req_wdata[ST_SIGCHG];
        iois8  <= req_wdata[ST_IOIS8];
        pwrdwn <= req_wdata[ST_PWRDWN];
      end
    end
  end

  always_comb begin
    rd_mux = 8'h00;
    if (idx_sel) begin
      rd_mux[IDX_W-1:0] = cfg_index;
    end else if (st_sel) begin
      rd_mux[ST_CHANGED] = changed;
      rd_mux[ST_SIGCHG]  = sigchg;
      rd_mux[ST_IOIS8]   = iois8;
      rd_mux[ST_PWRDWN]  = pwrdwn;
      rd_mux[ST_INT]     = int_req;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= 8'h00;
    end else begin
      rsp_valid <= req_valid && !req_write;
      if (req_valid && !req_write) rsp_data <= rd_mux;
    end
  end

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid); // R13
  AST_NO_RSP_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid); // R13
  AST_ST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && st_sel) |=> (rsp_data[4:3] == 2'b00 && !rsp_data[0])); // R3
  AST_IDX_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && idx_sel) |=> (rsp_data[7:6] == 2'b00)); // R2

endmodule

// File: rtl/card_cfg_pwr.sv
module card_cfg_pwr (
  input  logic clk,
  input  logic rst_n,
  input  logic st_wr,
  input  logic st_wr_pd,
  input  logic cur_pd,
  input  logic pwr_ack,
  input  logic pwr_ack_down,
  output logic ready
);

  logic busy_q;
  logic pd_flip, ack_match;

  assign pd_flip   = st_wr && (st_wr_pd != cur_pd);
  assign ack_match = pwr_ack && (pwr_ack_down == cur_pd);

  always_ff @(posedge clk) begin
    if (!rst_n)         busy_q <= 1'b0;
    else if (pd_flip)   busy_q <= 1'b1;
    else if (ack_match) busy_q <= 1'b0;
  end

  assign ready = !busy_q;

  AST_BUSY_ON_PD_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && st_wr_pd != cur_pd) |=> !ready); // R7
  AST_NO_BUSY_SAME_PD: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && st_wr && st_wr_pd == cur_pd) |=> ready); // R7
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !(pwr_ack && pwr_ack_down == cur_pd)) |=> !ready); // R8
  AST_READY_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !st_wr && pwr_ack && pwr_ack_down == cur_pd) |=> ready); // R8

endmodule

// File: rtl/card_cfg_iodec.sv
module card_cfg_iodec
  import card_cfg_pkg::*;
#(
  parameter int unsigned IO_AW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  map_mode_e        mode,
  input  logic [IO_AW-1:0] io_addr,
  input  logic [IO_AW-5:0] io_base,
  output logic             io_hit,
  output logic [2:0]       io_ofs
);

  localparam logic [IO_AW-1:0] PRI_M = IO_AW'(PRI_MAIN_BASE);
  localparam logic [IO_AW-1:0] PRI_A = IO_AW'(PRI_ALT_BASE);
  localparam logic [IO_AW-1:0] SEC_M = IO_AW'(SEC_MAIN_BASE);
  localparam logic [IO_AW-1:0] SEC_A = IO_AW'(SEC_ALT_BASE);

  logic main_any, alt_any, main_fix, alt_fix;

  always_comb begin
    main_any = (io_addr[IO_AW-1:4] == io_base) && !io_addr[3];
    alt_any  = (io_addr[IO_AW-1:4] == io_base) && (io_addr[3:1] == 3'b111);
    main_fix = 1'b0;
    alt_fix  = 1'b0;
    if (mode == MAP_IO_PRI) begin
      main_fix = (io_addr[IO_AW-1:3] == PRI_M[IO_AW-1:3]);
      alt_fix  = (io_addr[IO_AW-1:1] == PRI_A[IO_AW-1:1]);
    end else if (mode == MAP_IO_SEC) begin
      main_fix = (io_addr[IO_AW-1:3] == SEC_M[IO_AW-1:3]);
      alt_fix  = (io_addr[IO_AW-1:1] == SEC_A[IO_AW-1:1]);
    end
  end

  always_comb begin
    io_hit = 1'b0;
    io_ofs = 3'd0;
    unique case (mode)
      MAP_MEM: ;
      MAP_IO_ANY: begin
        if (main_any) begin
          io_hit = 1'b1;
          io_ofs = io_addr[2:0];
        end else if (alt_any) begin
          io_hit = 1'b1;
          io_ofs = {2'b11, io_addr[0]};
        end
      end
      default: begin
        if (main_fix) begin
          io_hit = 1'b1;
          io_ofs = io_addr[2:0];
        end else if (alt_fix) begin
          io_hit = 1'b1;
          io_ofs = {2'b11, io_addr[0]};
        end
      end
    endcase
  end

  AST_MEM_NEVER_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MAP_MEM) |-> !io_hit); // R12
  AST_MISS_OFS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !io_hit |-> (io_ofs == 3'd0)); // R10

endmodule

// File: rtl/card_cfg_ctrl.sv
module card_cfg_ctrl
  import card_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned IO_AW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              rsp_valid,
  output logic [7:0]        rsp_data,
  input  logic              rdy_chg,
  input  logic              wp_chg,
  input  logic              irq_pending,
  input  logic              irq_enable,
  input  logic              pwr_ack,
  input  logic              pwr_ack_down,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic [IO_AW-5:0]  io_base,
  output logic              stschg_n,
  output logic              rdy_bsy,
  output logic              pwr_down_req,
  output logic              io_hit,
  output logic [2:0]        io_ofs
);

  logic [IDX_W-1:0] cfg_index;
  logic sigchg, iois8, pwrdwn, st_wr, st_wr_pd;
  logic changed, int_req;
  map_mode_e mode;

  assign req_ready = 1'b1;
  assign changed   = rdy_chg | wp_chg;
  assign int_req   = irq_pending & irq_enable;
  assign mode      = map_mode_e'(cfg_index[1:0]);

  card_cfg_regs #(
    .ADDR_W(ADDR_W),
    .IDX_W (IDX_W)
  ) regs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .changed  (changed),
    .int_req  (int_req),
    .rsp_valid(rsp_valid),
    .rsp_data (rsp_data),
    .cfg_index(cfg_index),
    .sigchg   (sigchg),
    .iois8    (iois8),
    .pwrdwn   (pwrdwn),
    .st_wr    (st_wr),
    .st_wr_pd (st_wr_pd)
  );

  card_cfg_pwr pwr_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .st_wr       (st_wr),
    .st_wr_pd    (st_wr_pd),
    .cur_pd      (pwrdwn),
    .pwr_ack     (pwr_ack),
    .pwr_ack_down(pwr_ack_down),
    .ready       (rdy_bsy)
  );

  card_cfg_iodec #(
    .IO_AW(IO_AW)
  ) dec_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode   (mode),
    .io_addr(io_addr),
    .io_base(io_base),
    .io_hit (io_hit),
    .io_ofs (io_ofs)
  );

  // Status-change pin: only asserted in an I/O map with signalling enabled.
  assign stschg_n     = !(changed && sigchg && (mode != MAP_MEM));
  assign pwr_down_req = pwrdwn;

  AST_STSCHG_MEM_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MAP_MEM) |-> stschg_n); // R5
  AST_STSCHG_NEEDS_SIGCHG: assert property (@(posedge clk) disable iff (!rst_n)
    !sigchg |-> stschg_n); // R5
  AST_REQ_ALWAYS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready); // R13

endmodule

// File: tb/card_cfg_ctrl_tb_top.sv
`timescale 1ns/1ps
module card_cfg_ctrl_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [9:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic rdy_chg = 1'b0, wp_chg = 1'b0, irq_pending = 1'b0, irq_enable = 1'b0;
  logic pwr_ack = 1'b0, pwr_ack_down = 1'b0;
  logic [15:0] io_addr = '0;
  logic [11:0] io_base = 12'h0A5;
  logic req_ready, rsp_valid, stschg_n, rdy_bsy, pwr_down_req, io_hit;
  logic [7:0] rsp_data;
  logic [2:0] io_ofs;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  card_cfg_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rdy_chg(rdy_chg), .wp_chg(wp_chg),
    .irq_pending(irq_pending), .irq_enable(irq_enable),
    .pwr_ack(pwr_ack), .pwr_ack_down(pwr_ack_down),
    .io_addr(io_addr), .io_base(io_base),
    .stschg_n(stschg_n), .rdy_bsy(rdy_bsy), .pwr_down_req(pwr_down_req),
    .io_hit(io_hit), .io_ofs(io_ofs)
  );

  // {mode[1:0], addr[15:0], hit, ofs[2:0]} with io_base = 0x0A5
  localparam int NV = 17;
  localparam logic [21:0] VEC [NV] = '{
    {2'd0, 16'h01F0, 1'b0, 3'd0},
    {2'd0, 16'h0A50, 1'b0, 3'd0},
    {2'd1, 16'h0A50, 1'b1, 3'd0},
    {2'd1, 16'h0A57, 1'b1, 3'd7},
    {2'd1, 16'h0A58, 1'b0, 3'd0},
    {2'd1, 16'h0A5E, 1'b1, 3'd6},
    {2'd1, 16'h0A5F, 1'b1, 3'd7},
    {2'd1, 16'h0A60, 1'b0, 3'd0},
    {2'd2, 16'h01F0, 1'b1, 3'd0},
    {2'd2, 16'h01F5, 1'b1, 3'd5},
    {2'd2, 16'h03F6, 1'b1, 3'd6},
    {2'd2, 16'h03F5, 1'b0, 3'd0},
    {2'd2, 16'h0170, 1'b0, 3'd0},
    {2'd3, 16'h0177, 1'b1, 3'd7},
    {2'd3, 16'h0377, 1'b1, 3'd7},
    {2'd3, 16'h01F0, 1'b0, 3'd0},
    {2'd3, 16'h0378, 1'b0, 3'd0}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input string req, input logic [9:0] a, input logic [7:0] exp);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req, {15'd0, rsp_valid}, 16'd1);
    chk(req, {8'd0, rsp_data}, {8'd0, exp});
  endtask

  task automatic ack(input logic st);
    @(negedge clk);
    pwr_ack = 1'b1; pwr_ack_down = st;
    @(negedge clk);
    pwr_ack = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    io_addr = 16'h01F0;
    #1;
    chk("R1", {15'd0, rdy_bsy}, 16'd1);
    chk("R1", {15'd0, stschg_n}, 16'd1);
    chk("R1", {15'd0, pwr_down_req}, 16'd0);
    chk("R1", {15'd0, io_hit}, 16'd0);
    chk("R13", {15'd0, req_ready}, 16'd1);
    chk("R13", {15'd0, rsp_valid}, 16'd0);
    rd("R1", 10'h200, 8'h00);
    rd("R1", 10'h202, 8'h00);

    // R2 index register
    wr(10'h200, 8'hFF);
    rd("R2", 10'h200, 8'h3F);

    // R3 / R7 status write with all ones; only bits 6,5,2 stick
    wr(10'h202, 8'hFF);
    chk("R7", {15'd0, rdy_bsy}, 16'd0);
    rd("R3", 10'h202, 8'h64);
    chk("R3", {15'd0, pwr_down_req}, 16'd1);
    // R8 wrong-state ack ignored, right-state ack releases
    ack(1'b0);
    chk("R8", {15'd0, rdy_bsy}, 16'd0);
    ack(1'b1);
    chk("R8", {15'd0, rdy_bsy}, 16'd1);
    // R7 same PwrDwn value: no busy
    wr(10'h202, 8'h44);
    chk("R7", {15'd0, rdy_bsy}, 16'd1);
    // R7 / R8 toggle back down to active
    wr(10'h202, 8'h40);
    chk("R7", {15'd0, rdy_bsy}, 16'd0);
    repeat (3) @(negedge clk);
    chk("R8", {15'd0, rdy_bsy}, 16'd0);
    ack(1'b0);
    chk("R8", {15'd0, rdy_bsy}, 16'd1);

    // R4 Changed from either flag; R5 pin in I/O map 3
    rdy_chg = 1'b1;
    rd("R4", 10'h202, 8'hC0);
    #1 chk("R5", {15'd0, stschg_n}, 16'd0);
    rdy_chg = 1'b0; wp_chg = 1'b1;
    rd("R4", 10'h202, 8'hC0);
    wp_chg = 1'b0;
    #1 chk("R5", {15'd0, stschg_n}, 16'd1);
    rd("R4", 10'h202, 8'h40);
    wp_chg = 1'b1;
    wr(10'h202, 8'h00);
    #1 chk("R5", {15'd0, stschg_n}, 16'd1);
    wr(10'h202, 8'h40);
    wr(10'h200, 8'h00);
    #1 chk("R5", {15'd0, stschg_n}, 16'd1);
    wr(10'h200, 8'h02);
    #1 chk("R5", {15'd0, stschg_n}, 16'd0);

    // R6 IOis8 toggles with no output effect
    wr(10'h202, 8'h60);
    #1;
    chk("R6", {15'd0, stschg_n}, 16'd0);
    chk("R6", {15'd0, rdy_bsy}, 16'd1);
    chk("R6", {15'd0, pwr_down_req}, 16'd0);
    io_addr = 16'h03F7;
    #1;
    chk("R6", {12'd0, io_hit, io_ofs}, 16'h000F);
    rd("R6", 10'h202, 8'hE0);
    wr(10'h202, 8'h40);
    rd("R6", 10'h202, 8'hC0);
    wp_chg = 1'b0;

    // R9 interrupt in memory map and I/O map
    wr(10'h200, 8'h00);
    irq_pending = 1'b1; irq_enable = 1'b1;
    rd("R9", 10'h202, 8'h42);
    irq_enable = 1'b0;
    rd("R9", 10'h202, 8'h40);
    wr(10'h200, 8'h01);
    irq_enable = 1'b1;
    rd("R9", 10'h202, 8'h42);
    irq_pending = 1'b0;
    rd("R9", 10'h202, 8'h40);

    // R13 unmapped addresses
    wr(10'h204, 8'hAB);
    rd("R13", 10'h204, 8'h00);
    rd("R13", 10'h200, 8'h01);
    rd("R13", 10'h201, 8'h00);

    // R10 R11 R12 decode table
    for (int i = 0; i < NV; i++) begin
      logic [1:0] m;
      string tag;
      m = VEC[i][21:20];
      wr(10'h200, {6'd0, m});
      io_addr = VEC[i][19:4];
      #1;
      case (m)
        2'd1:    tag = "R10";
        2'd2:    tag = "R11";
        default: tag = "R12";
      endcase
      chk(tag, {12'd0, io_hit, io_ofs}, {12'd0, VEC[i][3:0]});
    end

    finish_run();
  end

endmodule